// File: doc/BRIEF.md
# Serial PCM Stream Bit Timing Unit

This block sits between one serial PCM stream and a byte-wide channel interface. It runs on a clock `clk` whose every cycle is one half-period of the stream's master clock, so each bit cell is an exact number of `clk` cycles. The block rebuilds the master clock level on `mclk_o`. It deserialises the received line into one byte per channel, reported with a one-cycle strobe and the channel index. It serialises bytes supplied per channel onto the transmit line, together with an output-enable flag for each channel.

Two bus timing conventions are supported. In the first, the frame pulse is active low and the master clock falls at the start of each bit cell. In the second, the frame pulse is active high and the clock edges are mirrored, so the clock rises at the start of each cell. The block picks the convention by itself from the polarity of each valid frame pulse and realigns the frame at the same moment. The rate input chooses one of two cell lengths: one master clock per bit at full rate, or two master clocks per bit at the lower rates. At the lower rates the receive sample is taken three quarters of the way into the cell.

Top module: `pcm_bit_timing`

## Requirements
- R1: A valid frame pulse is one idle sample of `fp_i`, then exactly two samples at the opposite level, then one idle sample again. When the pulse is low, `gci_o` becomes 0; when it is high, `gci_o` becomes 1. This is updated on every valid pulse. Pulses of one or three samples change neither `gci_o` nor the frame timing.
- R2: After the rising edge that takes the closing idle sample of a valid pulse, the cycle beginning at the second rising edge is tick 0 of bit 0 (the MSB) of channel 0.
- R3: With `rate_i`=0 a bit cell lasts 2 `clk` cycles (ticks 0..1). With `rate_i`=1 it lasts 4 cycles (ticks 0..3).
- R4: `mclk_o` equals bit 0 of the tick index XOR `gci_o`. It is therefore low in tick 0 under the active-low convention and high under the active-high one, and it toggles every cycle.
- R5: `rx_i` is taken in the last tick of each cell: tick 1 at `rate_i`=0 and tick 3 (three quarters of the cell) at `rate_i`=1. Values in the other ticks have no effect.
- R6: Bits leave MSB first. Bit k of a channel is on `tx_d_o` from tick 1 of its cell through tick 0 of the following cell.
- R7: `tx_chan_o` shows the channel whose cells are running. `tx_byte_i` and `tx_hiz_i` are captured in tick 0 of that channel's MSB cell.
- R8: `tx_oe_o` equals the inverse of the captured `tx_hiz_i`. It holds from tick 1 of the MSB cell until the next channel's capture.
- R9: `rx_valid_o` pulses for one cycle, in the cycle after the sample of a channel's last bit. At that point `rx_byte_o` holds the eight samples MSB first and `rx_chan_o` holds that channel's index.
- R10: After channel CHANNELS-1 the channel count returns to 0, with no frame pulse needed.
- R11: During reset `tx_d_o`, `tx_oe_o`, `rx_valid_o`, `gci_o`, `tx_chan_o` and `mclk_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-period tick clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_i | input | 1 | 0: one master clock per bit, 1: two per bit |
| fp_i | input | 1 | Frame pulse, either polarity |
| rx_i | input | 1 | Received serial line |
| tx_byte_i | input | BYTE_W | Byte for the channel on `tx_chan_o` |
| tx_hiz_i | input | 1 | Channel on `tx_chan_o` is three-stated |
| mclk_o | output | 1 | Rebuilt master clock level |
| gci_o | output | 1 | Detected convention, 1 for active-high pulse |
| tx_chan_o | output | clog2(CHANNELS) | Current transmit channel |
| tx_d_o | output | 1 | Transmit serial bit |
| tx_oe_o | output | 1 | Transmit enable for the current channel |
| rx_valid_o | output | 1 | Received byte strobe |
| rx_byte_o | output | BYTE_W | Received byte |
| rx_chan_o | output | clog2(CHANNELS) | Channel of the received byte |

## Verification
Some properties, such as the clock toggle and the cell-range check, assume that `rate_i` holds steady. They are therefore guarded on cycles where the rate just changed. The stimulus only changes the rate right before a resynchronising frame pulse. The assertions also assume that `fp_i` carries either clean two-sample pulses or the short and long glitches that must be ignored. The bench drives only those shapes, always returning to the idle level of the convention in force. It does not let a glitch run next to a real pulse.

// File: rtl/pcm_bt_pkg.sv
package pcm_bt_pkg;

  // last tick index of a bit cell for the selected rate
  function automatic logic [1:0] cell_last(input logic rate);
    return rate ? 2'd3 : 2'd1;
  endfunction

  // tick in which the receive line is taken
  function automatic logic [1:0] sample_tick(input logic rate);
    return rate ? 2'd3 : 2'd1;
  endfunction

  // tick advance with wrap at the end of the cell
  function automatic logic [1:0] next_tick(input logic [1:0] t, input logic rate);
    return (t >= cell_last(rate)) ? 2'd0 : t + 2'd1;
  endfunction

endpackage

// File: rtl/pcm_fp_detect.sv
module pcm_fp_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic fp_i,
  output logic fp_hit,
  output logic gci_q
);
  // smp[0] newest sample, smp[3] oldest
  logic [3:0] smp;

  // idle, active, active, idle
  assign fp_hit = (smp[3] == smp[0]) && (smp[2] == smp[1]) && (smp[1] != smp[0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp   <= '0;
      gci_q <= 1'b0;
    end else begin
      smp <= {smp[2:0], fp_i};
      if (fp_hit) gci_q <= smp[1];
    end
  end

  // convention follows the active level of the pulse just seen
  assert_conv_follows_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fp_hit |=> (gci_q == $past(smp[1])));

endmodule

// File: rtl/pcm_bit_timer.sv
module pcm_bit_timer #(
  parameter int CHANNELS = 32,
  parameter int BYTE_W   = 8,
  localparam int CW = $clog2(CHANNELS),
  localparam int BW = $clog2(BYTE_W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rate_i,
  input  logic          fp_hit,
  output logic [1:0]    tick,
  output logic [BW-1:0] bit_idx,
  output logic [CW-1:0] chan,
  output logic          launch,
  output logic          sample,
  output logic          first_bit,
  output logic          last_bit
);
  import pcm_bt_pkg::*;

  logic cell_end;
  logic frame_end_chan;

  assign cell_end       = (tick >= cell_last(rate_i));
  assign launch         = (tick == 2'd0);
  assign sample         = (tick == sample_tick(rate_i));
  assign first_bit      = (bit_idx == '0);
  assign last_bit       = (bit_idx == BW'(BYTE_W - 1));
  assign frame_end_chan = (chan == CW'(CHANNELS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || fp_hit) begin
      tick    <= '0;
      bit_idx <= '0;
      chan    <= '0;
    end else begin
      tick <= next_tick(tick, rate_i);
      if (cell_end) begin
        if (last_bit) begin
          bit_idx <= '0;
          chan    <= frame_end_chan ? '0 : chan + CW'(1);
        end else begin
          bit_idx <= bit_idx + BW'(1);
        end
      end
    end
  end

  assert_align_on_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fp_hit |=> (tick == 2'd0 && bit_idx == '0 && chan == '0));

  assert_tick_in_cell_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_i == $past(rate_i)) |-> (tick <= cell_last(rate_i)));

  assert_chan_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end_chan && last_bit && cell_end && !fp_hit) |=> (chan == '0));

endmodule

// File: rtl/pcm_tx_ser.sv
module pcm_tx_ser #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              first_bit,
  input  logic [BYTE_W-1:0] tx_byte_i,
  input  logic              tx_hiz_i,
  output logic              tx_d,
  output logic              tx_oe
);
  logic [BYTE_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh    <= '0;
      tx_d  <= 1'b0;
      tx_oe <= 1'b0;
    end else if (launch) begin
      if (first_bit) begin
        tx_d  <= tx_byte_i[BYTE_W-1];
        sh    <= tx_byte_i << 1;
        tx_oe <= ~tx_hiz_i;
      end else begin
        tx_d <= sh[BYTE_W-1];
        sh   <= sh << 1;
      end
    end
  end

  assert_bit_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !launch |=> $stable(tx_d));

  assert_oe_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(launch && first_bit) |=> $stable(tx_oe));

endmodule

// File: rtl/pcm_rx_deser.sv
module pcm_rx_deser #(
  parameter int CHANNELS = 32,
  parameter int BYTE_W   = 8,
  localparam int CW = $clog2(CHANNELS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample,
  input  logic              last_bit,
  input  logic [CW-1:0]     chan,
  input  logic              rx_i,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_byte,
  output logic [CW-1:0]     rx_chan
);
  logic [BYTE_W-1:0] acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc      <= '0;
      rx_valid <= 1'b0;
      rx_byte  <= '0;
      rx_chan  <= '0;
    end else begin
      rx_valid <= sample && last_bit;
      if (sample) begin
        acc <= {acc[BYTE_W-2:0], rx_i};
        if (last_bit) begin
          rx_byte <= {acc[BYTE_W-2:0], rx_i};
          rx_chan <= chan;
        end
      end
    end
  end

  assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

endmodule

// File: rtl/pcm_bit_timing.sv
module pcm_bit_timing #(
  parameter int CHANNELS = 32,
  parameter int BYTE_W   = 8,
  localparam int CW = $clog2(CHANNELS),
  localparam int BW = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rate_i,
  input  logic              fp_i,
  input  logic              rx_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  input  logic              tx_hiz_i,
  output logic              mclk_o,
  output logic              gci_o,
  output logic [CW-1:0]     tx_chan_o,
  output logic              tx_d_o,
  output logic              tx_oe_o,
  output logic              rx_valid_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic [CW-1:0]     rx_chan_o
);
  // named internal events
  logic          fp_hit;
  logic [1:0]    tick;
  logic [BW-1:0] bit_idx;
  logic [CW-1:0] chan;
  logic          launch;
  logic          sample;
  logic          first_bit;
  logic          last_bit;

  pcm_fp_detect u_fp (
    .clk(clk), .rst_n(rst_n), .fp_i(fp_i), .fp_hit(fp_hit), .gci_q(gci_o)
  );

  pcm_bit_timer #(.CHANNELS(CHANNELS), .BYTE_W(BYTE_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .rate_i(rate_i), .fp_hit(fp_hit),
    .tick(tick), .bit_idx(bit_idx), .chan(chan), .launch(launch),
    .sample(sample), .first_bit(first_bit), .last_bit(last_bit)
  );

  pcm_tx_ser #(.BYTE_W(BYTE_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .launch(launch), .first_bit(first_bit),
    .tx_byte_i(tx_byte_i), .tx_hiz_i(tx_hiz_i), .tx_d(tx_d_o), .tx_oe(tx_oe_o)
  );

  pcm_rx_deser #(.CHANNELS(CHANNELS), .BYTE_W(BYTE_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .sample(sample), .last_bit(last_bit),
    .chan(chan), .rx_i(rx_i), .rx_valid(rx_valid_o), .rx_byte(rx_byte_o),
    .rx_chan(rx_chan_o)
  );

  assign tx_chan_o = chan;
  // launch edge falls in one convention and rises in the other
  assign mclk_o    = tick[0] ^ gci_o;

  assert_mclk_toggles_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!fp_hit && rate_i == $past(rate_i)) |=> (mclk_o != $past(mclk_o)));

endmodule

// File: tb/pcm_bit_timing_tb_top.sv
module pcm_bit_timing_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CH = 4;

  logic       clk, rst_n, rate_i, fp_i, rx_i, rx_drv, loop_en;
  logic [7:0] tx_byte_i;
  logic       tx_hiz_i;
  logic       mclk_o, gci_o, tx_d_o, tx_oe_o, rx_valid_o;
  logic [1:0] tx_chan_o, rx_chan_o;
  logic [7:0] rx_byte_o;
  int checks = 0;
  int fails  = 0;
  int seed   = 1;

  pcm_bit_timing #(.CHANNELS(CH), .BYTE_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .rate_i(rate_i), .fp_i(fp_i), .rx_i(rx_i),
    .tx_byte_i(tx_byte_i), .tx_hiz_i(tx_hiz_i), .mclk_o(mclk_o), .gci_o(gci_o),
    .tx_chan_o(tx_chan_o), .tx_d_o(tx_d_o), .tx_oe_o(tx_oe_o),
    .rx_valid_o(rx_valid_o), .rx_byte_o(rx_byte_o), .rx_chan_o(rx_chan_o)
  );

  function automatic logic [7:0] pat(input int ch, input int s);
    return 8'((ch * 53 + s * 29 + 7) & 255);
  endfunction

  assign tx_byte_i = pat(int'(tx_chan_o), seed);
  assign tx_hiz_i  = (tx_chan_o == 2'd2);
  assign rx_i      = loop_en ? tx_d_o : rx_drv;

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic sync(input bit gci);
    @(negedge clk);
    fp_i = ~gci;
    repeat (6) @(negedge clk);
    fp_i = gci;
    @(negedge clk);
    @(negedge clk);
    fp_i = ~gci;
    @(negedge clk);
  endtask

  // k counts ticks from the first tick after alignment (R2)
  task automatic run(input int k0, input int n, input bit gci, input bit rate,
                     input int g0, input int glen);
    for (int k = k0; k < k0 + n; k++) begin
      int cell_t, ti, bg, ch, bt, pch;
      logic [7:0] b, pb;
      logic idle;
      bit exp_v;
      cell_t = rate ? 4 : 2;
      ti = k % cell_t;
      bg = k / cell_t;
      ch = (bg / 8) % CH;
      bt = bg % 8;
      idle = ~gci;
      @(negedge clk);
      fp_i = (k >= g0 && k < g0 + glen) ? ~idle : idle;
      b = pat(ch, seed);
      if (!loop_en) rx_drv = (ti == cell_t - 1) ? b[7 - bt] : ~b[7 - bt];
      check(gci_o == gci, "R1", "gci_o", int'(gci_o), int'(gci));
      check(mclk_o == ((ti % 2 == 1) ^ gci), "R4", "mclk_o", int'(mclk_o),
            int'((ti % 2 == 1) ^ gci));
      check(int'(tx_chan_o) == ch, (bg / 8 >= CH) ? "R10" : "R7", "tx_chan_o",
            int'(tx_chan_o), ch);
      if (ti != 0)
        check(tx_d_o == b[7 - bt], rate ? "R6/R3" : "R6", "tx_d_o", int'(tx_d_o),
              int'(b[7 - bt]));
      if (ti != 0 || bt != 0)
        check(tx_oe_o == (ch != 2), "R8", "tx_oe_o", int'(tx_oe_o), int'(ch != 2));
      if (k > 0) begin
        exp_v = (ti == 0 && bt == 0 && k >= 8 * cell_t);
        check(rx_valid_o == exp_v, "R9", "rx_valid_o", int'(rx_valid_o), int'(exp_v));
        if (exp_v) begin
          pch = (bg / 8 - 1) % CH;
          pb = pat(pch, seed);
          check(int'(rx_chan_o) == pch, "R9", "rx_chan_o", int'(rx_chan_o), pch);
          check(rx_byte_o == pb, loop_en ? "R9" : "R5", "rx_byte_o",
                int'(rx_byte_o), int'(pb));
        end
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; fp_i = 1'b1; rate_i = 1'b0; loop_en = 1'b1; rx_drv = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(tx_d_o == 1'b0, "R11", "tx_d_o", int'(tx_d_o), 0);
    check(tx_oe_o == 1'b0, "R11", "tx_oe_o", int'(tx_oe_o), 0);
    check(rx_valid_o == 1'b0, "R11", "rx_valid_o", int'(rx_valid_o), 0);
    check(gci_o == 1'b0, "R11", "gci_o", int'(gci_o), 0);
    check(tx_chan_o == 2'd0, "R11", "tx_chan_o", int'(tx_chan_o), 0);
    check(mclk_o == 1'b0, "R11", "mclk_o", int'(mclk_o), 0);
    rst_n = 1'b1;

    // sweep convention x rate in loopback, 1.5 frames each (R1..R4, R6..R10)
    for (int conv = 0; conv < 2; conv++) begin
      for (int r = 0; r < 2; r++) begin
        rate_i = r[0];
        seed = conv * 2 + r + 1;
        sync(conv[0]);
        run(0, CH * 8 * (r == 1 ? 4 : 2) * 3 / 2, conv[0], r[0], -10, 0);
      end
    end

    // R5 sample point: line holds the bit only in the sample tick
    loop_en = 1'b0;
    for (int r = 0; r < 2; r++) begin
      rate_i = r[0];
      seed = 9 + r;
      sync(~r[0]);
      run(0, CH * 8 * (r == 1 ? 4 : 2) + 8, ~r[0], r[0], -10, 0);
    end
    loop_en = 1'b1;

    // R1 ignored pulses: one-sample then three-sample glitch, timing continues
    rate_i = 1'b1;
    seed = 13;
    sync(1'b1);
    run(0, 150, 1'b1, 1'b1, 20, 1);
    run(150, 150, 1'b1, 1'b1, 170, 3);
    sync(1'b0);
    run(0, 150, 1'b0, 1'b1, 40, 1);
    run(150, 100, 1'b0, 1'b1, 190, 3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule